// File: doc/BRIEF.md
# Three-Wire Packet Handshake Controller

This block is the host side of a byte-packet link to a small peripheral controller. The two sides share an 8-bit shift register and three handshake lines. The peripheral pulls `treq_n` low when it has a packet to deliver. The host drives `tip_n` low while a transaction is open and flips `tack` to acknowledge each byte. Bit-level shifting is handled elsewhere. Each completed byte arrives here as a one-cycle `sr_done` strobe, and every strobe moves the controller exactly one step through its five states: listen, receive, receive-end, send-start and send.

Incoming bytes go into a small buffer. When a packet ends, the controller pulses `rx_done` with the byte count, and the host reads the bytes through an indexed read port. If the peripheral asks again at the moment a packet closes, the next packet is chained straight on. An outgoing packet is written through a write port, or queued as a ready-made three-byte autopoll command. It is started from listen whenever the line is quiet. If the peripheral requests the line during the first byte, the send is abandoned and retried later.

Top module: `hsk_xfer_ctrl`

## Requirements
- R1: After reset `tip_n` and `tack` are 1, `sr_out_dir` is 0 (input), and `rx_done` and `sr_tx_load` are 0.
- R2: In listen, an `sr_done` strobe with `treq_n` high is ignored: `tip_n` stays 1 and the next packet is received as normal.
- R3: In listen, a strobe with `treq_n` low discards the shift-register byte, drives `tip_n` to 0 with `tack` unchanged, and enters receive.
- R4: In receive, each strobe stores `sr_rx_byte`. With `treq_n` low it toggles `tack`. With `treq_n` high it sets `tack` and `tip_n` to 1 and enters receive-end.
- R5: In receive-end, a strobe discards the byte, pulses `rx_done` for one cycle with `rx_len` equal to the stored count, and leaves the bytes readable at `rx_rd_idx` 0 onward.
- R6: Bytes that arrive after the buffer holds RX_DEPTH bytes are dropped, and `rx_len` reports RX_DEPTH.
- R7: A receive-end strobe with `treq_n` low drives `tip_n` to 0 and returns to receive. The next strobe stores the first byte of a new packet at index 0.
- R8: A send starts only from listen, with a non-zero pending count and `treq_n` high. It sets `sr_out_dir` to 1, loads byte 0 with a `sr_tx_load` pulse and drives `tip_n` to 0.
- R9: In send-start, a strobe with `treq_n` high loads byte 1 and toggles `tack`.
- R10: In send, each strobe loads the next byte and toggles `tack`. The strobe after the last byte sets `sr_out_dir` to 0, sets `tip_n` and `tack` to 1, and clears the packet so that it is not sent again.
- R11: In send-start, a strobe with `treq_n` low is a collision. It sets `sr_out_dir` to 0 and `tip_n` and `tack` to 1, and keeps the packet, which restarts from byte 0 once `treq_n` is high in listen.
- R12: An `ap_req` pulse while nothing is pending queues the three bytes 0x01, 0x01, then 0x01 if `ap_enable` is 1 or 0x00 if it is 0.
- R13: Byte writes, commits and `ap_req` are ignored while a packet is pending, and the bytes sent do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| treq_n | input | 1 | Peripheral request, active low |
| sr_done | input | 1 | Shift-register byte completion strobe |
| sr_rx_byte | input | 8 | Byte captured by the shift register |
| sr_tx_byte | output | 8 | Byte to load into the shift register |
| sr_tx_load | output | 1 | One-cycle pulse when `sr_tx_byte` is new |
| sr_out_dir | output | 1 | Shift direction, 1 = output |
| tip_n | output | 1 | Transaction in progress, active low |
| tack | output | 1 | Byte acknowledge, toggles |
| rx_done | output | 1 | Packet received pulse |
| rx_len | output | $clog2(RX_DEPTH+1) | Length of the last received packet |
| rx_rd_idx | input | $clog2(RX_DEPTH) | Receive buffer read index |
| rx_rd_data | output | 8 | Receive buffer byte at `rx_rd_idx` |
| tx_wr_en | input | 1 | Outgoing byte write strobe |
| tx_wr_idx | input | $clog2(TX_DEPTH) | Outgoing byte index |
| tx_wr_data | input | 8 | Outgoing byte value |
| tx_commit | input | 1 | Queue the outgoing packet |
| tx_commit_len | input | $clog2(TX_DEPTH+1) | Outgoing byte count |
| ap_req | input | 1 | Queue the autopoll command packet |
| ap_enable | input | 1 | Autopoll on (1) or off (0) |

## Verification
The bench uses the default RX_DEPTH of 16 and TX_DEPTH of 16. With these values a twenty-byte incoming burst overflows the buffer, so the dropped-byte rule and the saturated length can be observed. The outgoing packets are two, three and four bytes long. This covers the case where the packet ends right after the send-start step as well as longer runs in send. Collision, chaining and the lockout of the write port are each driven on purpose with the defaults.

// File: rtl/hsk_xfer_ctrl.sv
module hsk_xfer_ctrl #(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          treq_n,
  input  logic                          sr_done,
  input  logic [7:0]                    sr_rx_byte,
  output logic [7:0]                    sr_tx_byte,
  output logic                          sr_tx_load,
  output logic                          sr_out_dir,
  output logic                          tip_n,
  output logic                          tack,
  output logic                          rx_done,
  output logic [$clog2(RX_DEPTH+1)-1:0] rx_len,
  input  logic [$clog2(RX_DEPTH)-1:0]   rx_rd_idx,
  output logic [7:0]                    rx_rd_data,
  input  logic                          tx_wr_en,
  input  logic [$clog2(TX_DEPTH)-1:0]   tx_wr_idx,
  input  logic [7:0]                    tx_wr_data,
  input  logic                          tx_commit,
  input  logic [$clog2(TX_DEPTH+1)-1:0] tx_commit_len,
  input  logic                          ap_req,
  input  logic                          ap_enable
);
  localparam int RXIW = $clog2(RX_DEPTH);
  localparam int RXCW = $clog2(RX_DEPTH+1);
  localparam int TXIW = $clog2(TX_DEPTH);
  localparam int TXCW = $clog2(TX_DEPTH+1);

  typedef enum logic [2:0] {S_LISTEN, S_RECV, S_REND, S_SSTART, S_SEND} st_t;

  st_t             st;
  logic [7:0]      rxb [RX_DEPTH];
  logic [7:0]      txb [TX_DEPTH];
  logic [RXCW-1:0] rx_cnt;
  logic [TXCW-1:0] tx_cnt;
  logic [TXCW-1:0] tx_idx;

  wire tx_idle  = (tx_cnt == '0);
  wire send_go  = (st == S_LISTEN) && !sr_done && !tx_idle && treq_n;
  wire rx_store = sr_done && (st == S_RECV) && (rx_cnt < RXCW'(RX_DEPTH));

  assign rx_rd_data = rxb[rx_rd_idx];

  always_ff @(posedge clk) begin
    if (rx_store) rxb[rx_cnt[RXIW-1:0]] <= sr_rx_byte;
  end

  always_ff @(posedge clk) begin
    if (tx_idle) begin
      if (ap_req) begin
        txb[TXIW'(0)] <= 8'h01;
        txb[TXIW'(1)] <= 8'h01;
        txb[TXIW'(2)] <= {7'b0, ap_enable};
      end else if (tx_wr_en) begin
        txb[tx_wr_idx] <= tx_wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_LISTEN;
      tip_n      <= 1'b1;
      tack       <= 1'b1;
      sr_out_dir <= 1'b0;
      sr_tx_byte <= '0;
      sr_tx_load <= 1'b0;
      rx_cnt     <= '0;
      rx_len     <= '0;
      rx_done    <= 1'b0;
      tx_cnt     <= '0;
      tx_idx     <= '0;
    end else begin
      rx_done    <= 1'b0;
      sr_tx_load <= 1'b0;
      if (tx_idle) begin
        if (ap_req)         tx_cnt <= TXCW'(3);
        else if (tx_commit) tx_cnt <= tx_commit_len;
      end
      if (send_go) begin
        sr_out_dir <= 1'b1;
        sr_tx_byte <= txb[TXIW'(0)];
        sr_tx_load <= 1'b1;
        tip_n      <= 1'b0;
        st         <= S_SSTART;
      end else if (sr_done) begin
        case (st)
          S_LISTEN: if (!treq_n) begin
            tip_n <= 1'b0;
            st    <= S_RECV;
          end
          S_RECV: begin
            if (rx_store) rx_cnt <= rx_cnt + RXCW'(1);
            if (!treq_n) tack <= ~tack;
            else begin
              tack  <= 1'b1;
              tip_n <= 1'b1;
              st    <= S_REND;
            end
          end
          S_REND: begin
            rx_done <= 1'b1;
            rx_len  <= rx_cnt;
            rx_cnt  <= '0;
            if (!treq_n) begin
              tip_n <= 1'b0;
              st    <= S_RECV;
            end else begin
              st <= S_LISTEN;
            end
          end
          S_SSTART: if (!treq_n) begin
            sr_out_dir <= 1'b0;
            tip_n      <= 1'b1;
            tack       <= 1'b1;
            st         <= S_LISTEN;
          end else begin
            sr_tx_byte <= txb[TXIW'(1)];
            sr_tx_load <= 1'b1;
            tack       <= ~tack;
            tx_idx     <= TXCW'(2);
            st         <= S_SEND;
          end
          S_SEND: if (tx_idx < tx_cnt) begin
            sr_tx_byte <= txb[tx_idx[TXIW-1:0]];
            sr_tx_load <= 1'b1;
            tx_idx     <= tx_idx + TXCW'(1);
            tack       <= ~tack;
          end else begin
            tx_cnt     <= '0;
            tx_idx     <= '0;
            sr_out_dir <= 1'b0;
            tack       <= 1'b1;
            tip_n      <= 1'b1;
            st         <= S_LISTEN;
          end
          default: st <= S_LISTEN;
        endcase
      end
    end
  end

  a_r2_spurious_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LISTEN && sr_done && treq_n) |=> (st == S_LISTEN && tip_n && !sr_tx_load));

  a_r3_rx_holds_tip: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RECV) |-> (!tip_n && !sr_out_dir));

  a_r6_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (rx_len <= RXCW'(RX_DEPTH)));

  a_r8_send_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LISTEN && !sr_done && !tx_idle && treq_n) |=> (st == S_SSTART && sr_tx_load && sr_out_dir && !tip_n));

  a_r8_send_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SSTART || st == S_SEND) |-> (sr_out_dir && !tip_n && !tx_idle));

  a_r10_tack_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && sr_done && tx_idx < tx_cnt) |=> (tack != $past(tack) && sr_tx_load));

  a_r11_collision_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SSTART && sr_done && !treq_n) |=> (st == S_LISTEN && tip_n && tack && !sr_out_dir && tx_cnt == $past(tx_cnt)));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
endmodule

// File: tb/hsk_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module hsk_xfer_ctrl_tb;
  localparam int RXD = 16;
  localparam int TXD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic treq_n = 1'b1, sr_done = 1'b0;
  logic [7:0] sr_rx_byte = '0;
  logic [7:0] sr_tx_byte;
  logic sr_tx_load, sr_out_dir, tip_n, tack, rx_done;
  logic [$clog2(RXD+1)-1:0] rx_len;
  logic [$clog2(RXD)-1:0] rx_rd_idx = '0;
  logic [7:0] rx_rd_data;
  logic tx_wr_en = 1'b0;
  logic [$clog2(TXD)-1:0] tx_wr_idx = '0;
  logic [7:0] tx_wr_data = '0;
  logic tx_commit = 1'b0;
  logic [$clog2(TXD+1)-1:0] tx_commit_len = '0;
  logic ap_req = 1'b0, ap_enable = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] txq[$];
  string      txtag[$];
  int         rxlenq[$];
  logic [7:0] rxdq[$];

  always #5 clk = ~clk;

  hsk_xfer_ctrl #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .treq_n(treq_n), .sr_done(sr_done), .sr_rx_byte(sr_rx_byte),
    .sr_tx_byte(sr_tx_byte), .sr_tx_load(sr_tx_load), .sr_out_dir(sr_out_dir),
    .tip_n(tip_n), .tack(tack), .rx_done(rx_done), .rx_len(rx_len),
    .rx_rd_idx(rx_rd_idx), .rx_rd_data(rx_rd_data), .tx_wr_en(tx_wr_en),
    .tx_wr_idx(tx_wr_idx), .tx_wr_data(tx_wr_data), .tx_commit(tx_commit),
    .tx_commit_len(tx_commit_len), .ap_req(ap_req), .ap_enable(ap_enable));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && sr_tx_load) begin
      if (txq.size() == 0) chk(1'b0, "R10 unexpected load", sr_tx_byte, 0);
      else begin
        logic [7:0] e;
        string t;
        e = txq.pop_front();
        t = txtag.pop_front();
        chk(sr_tx_byte == e, t, sr_tx_byte, e);
      end
    end
    if (rst_n && rx_done) begin
      if (rxlenq.size() == 0) chk(1'b0, "R5 unexpected done", rx_len, 0);
      else begin
        int el;
        el = rxlenq.pop_front();
        chk(int'(rx_len) == el, "R5/R6 length", rx_len, el);
        for (int i = 0; i < el; i++) begin
          logic [7:0] eb;
          eb = rxdq.pop_front();
          rx_rd_idx = i[$clog2(RXD)-1:0];
          #0.1;
          chk(rx_rd_data == eb, "R5/R6/R7 data", rx_rd_data, eb);
        end
      end
    end
  end

  task automatic ev(input logic tr, input logic [7:0] b);
    @(negedge clk);
    treq_n = tr; sr_rx_byte = b; sr_done = 1'b1;
    @(negedge clk);
    sr_done = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    tx_wr_en = 1'b1; tx_wr_idx = idx[$clog2(TXD)-1:0]; tx_wr_data = d;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic commit(input int n);
    @(negedge clk);
    tx_commit = 1'b1; tx_commit_len = n[$clog2(TXD+1)-1:0];
    @(negedge clk);
    tx_commit = 1'b0;
  endtask

  task automatic autopoll(input logic en);
    @(negedge clk);
    ap_req = 1'b1; ap_enable = en;
    @(negedge clk);
    ap_req = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b, input string t);
    txq.push_back(b); txtag.push_back(t);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic exp_tack;
    repeat (3) @(negedge clk);
    chk(tip_n == 1 && tack == 1, "R1 tip/tack", {tip_n, tack}, 2'b11);
    chk(sr_out_dir == 0 && rx_done == 0 && sr_tx_load == 0, "R1 dir/done/load",
        {sr_out_dir, rx_done, sr_tx_load}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: spurious strobe in listen
    ev(1'b1, 8'hAA);
    chk(tip_n == 1, "R2 tip after spurious", tip_n, 1);

    // R3/R4/R5: three-byte packet
    ev(1'b0, 8'h99);
    chk(tip_n == 0 && tack == 1, "R3 enter receive", {tip_n, tack}, 2'b01);
    ev(1'b0, 8'h11);
    chk(tack == 0, "R4 tack toggle 1", tack, 0);
    ev(1'b0, 8'h22);
    chk(tack == 1, "R4 tack toggle 2", tack, 1);
    ev(1'b1, 8'h33);
    chk(tip_n == 1 && tack == 1, "R4 end lines", {tip_n, tack}, 2'b11);
    rxlenq.push_back(3); rxdq.push_back(8'h11); rxdq.push_back(8'h22); rxdq.push_back(8'h33);
    ev(1'b1, 8'hEE);
    chk(rx_done == 1, "R5 done pulse", rx_done, 1);
    @(negedge clk);
    chk(rx_done == 0, "R5 done single", rx_done, 0);

    // R6: overflow
    ev(1'b0, 8'h00);
    rxlenq.push_back(RXD);
    for (int i = 0; i < 20; i++) begin
      if (i < RXD) rxdq.push_back(8'h40 + i[7:0]);
      ev((i == 19) ? 1'b1 : 1'b0, 8'h40 + i[7:0]);
    end
    ev(1'b1, 8'hEE);
    chk(rx_done == 1, "R6 done after overflow", rx_done, 1);

    // R7: chained packets
    ev(1'b0, 8'h00);
    ev(1'b0, 8'hA1);
    ev(1'b1, 8'hA2);
    rxlenq.push_back(2); rxdq.push_back(8'hA1); rxdq.push_back(8'hA2);
    ev(1'b0, 8'hEE);
    chk(tip_n == 0, "R7 chained tip", tip_n, 0);
    ev(1'b0, 8'hB1);
    ev(1'b1, 8'hB2);
    rxlenq.push_back(2); rxdq.push_back(8'hB1); rxdq.push_back(8'hB2);
    ev(1'b1, 8'hEE);
    repeat (2) @(negedge clk);

    // R8/R9/R10/R13: four-byte send
    treq_n = 1'b1;
    wr(0, 8'hD0); wr(1, 8'hD1); wr(2, 8'hD2); wr(3, 8'hD3);
    push_tx(8'hD0, "R8 byte0"); push_tx(8'hD1, "R9 byte1");
    push_tx(8'hD2, "R10 byte2"); push_tx(8'hD3, "R13 byte3");
    commit(4);
    @(negedge clk);
    chk(sr_out_dir == 1 && tip_n == 0, "R8 send lines", {sr_out_dir, tip_n}, 2'b10);
    wr(3, 8'hFF); commit(1); autopoll(1'b0);
    exp_tack = tack;
    ev(1'b1, 8'h00);
    exp_tack = ~exp_tack;
    chk(tack == exp_tack, "R9 tack toggle", tack, exp_tack);
    ev(1'b1, 8'h00);
    exp_tack = ~exp_tack;
    chk(tack == exp_tack, "R10 tack toggle", tack, exp_tack);
    ev(1'b1, 8'h00);
    ev(1'b1, 8'h00);
    chk(sr_out_dir == 0 && tip_n == 1 && tack == 1, "R10 end lines",
        {sr_out_dir, tip_n, tack}, 3'b011);
    repeat (6) @(negedge clk);
    chk(txq.size() == 0, "R10 queue drained", txq.size(), 0);

    // R8: no start while treq_n low
    treq_n = 1'b0;
    wr(0, 8'hE0); wr(1, 8'hE1); commit(2);
    repeat (5) @(negedge clk);
    chk(sr_out_dir == 0 && tip_n == 1, "R8 held by treq", {sr_out_dir, tip_n}, 2'b01);
    push_tx(8'hE0, "R8 byte0 len2"); push_tx(8'hE1, "R9 byte1 len2");
    treq_n = 1'b1;
    repeat (2) @(negedge clk);
    ev(1'b1, 8'h00);
    ev(1'b1, 8'h00);
    chk(sr_out_dir == 0 && tip_n == 1, "R10 short end", {sr_out_dir, tip_n}, 2'b01);

    // R11/R12: collision on autopoll enable
    push_tx(8'h01, "R12 first try byte0");
    autopoll(1'b1);
    @(negedge clk);
    ev(1'b0, 8'h55);
    chk(sr_out_dir == 0 && tip_n == 1 && tack == 1, "R11 collision lines",
        {sr_out_dir, tip_n, tack}, 3'b011);
    repeat (4) @(negedge clk);
    chk(sr_out_dir == 0, "R11 held during request", sr_out_dir, 0);
    push_tx(8'h01, "R11 retry byte0"); push_tx(8'h01, "R12 byte1"); push_tx(8'h01, "R12 enable");
    treq_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sr_out_dir == 1, "R11 retry started", sr_out_dir, 1);
    ev(1'b1, 8'h00); ev(1'b1, 8'h00); ev(1'b1, 8'h00);

    // R12: autopoll disable
    push_tx(8'h01, "R12 off byte0"); push_tx(8'h01, "R12 off byte1"); push_tx(8'h00, "R12 disable");
    autopoll(1'b0);
    @(negedge clk);
    ev(1'b1, 8'h00); ev(1'b1, 8'h00); ev(1'b1, 8'h00);
    repeat (4) @(negedge clk);
    chk(txq.size() == 0 && rxlenq.size() == 0, "R12 scoreboard empty", txq.size() + rxlenq.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule